// File: doc/BRIEF.md
# ACPI Power-Management Timer and Event Unit

This block holds the fixed power-management registers of a chipset: a free-running timer clocked by a tick strobe, a status register whose bits are cleared by writing ones, an enable register, and a control register. Whenever an enabled status bit is set, the block raises a level system-control interrupt (SCI). It is reached through a simple word-wide I/O port. Reads are combinational on the current offset. Writes take effect at the clock edge on which the write strobe is high.

Writing the control register with the sleep-enable bit set starts a sleep action. The sleep-type field then selects either a power-off request or a resume-style reset request. Each request leaves the block as a one-cycle pulse. A separate two-byte port carries a command byte and a scratch status byte. Two magic command values set or clear the SCI-enable bit. When the SMI-enable input is high, every command write also sends out a one-cycle SMI request. A power-button event input feeds the status register, gated by its enable bit.

Top module: `acpiPmUnit`

## Requirements
- R1: After reset the timer, status, enable, control, command byte and scratch byte all read zero, and sci, smiReq, shutdownReq and resetReq are low.
- R2: The timer increments by one at each clock edge where tickEn is high and holds otherwise. It wraps at its width (TMR_W bits, default 24). It reads at offset 0x08, zero-extended to 32 bits, and writes to that offset are ignored.
- R3: Status bit 0 (timer overflow) sets at the edge where a tick changes the timer's most significant bit, whether from 0 to 1 or from 1 to 0.
- R4: The status register is at offset 0x00. Writing a 1 to a bit clears that bit, and writing a 0 leaves it alone. If a bit is set by an event and cleared by a write at the same edge, the bit ends up set.
- R5: The enable register at offset 0x02 stores all 16 written bits. Every offset other than 0x00, 0x02, 0x04 and 0x08 reads zero, and writes to those offsets change nothing.
- R6: sci is high exactly while status AND enable is nonzero on bits 0, 5, 8 or 10 (mask 0x0521).
- R7: The control register at offset 0x04 stores a written value with bit 13 forced to zero.
- R8: A control write with bit 13 set and bits 12:10 equal to 0 makes shutdownReq high for the single cycle after the write edge.
- R9: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 and 8 and makes resetReq high for the single cycle after the write edge. Sleep types 2 to 7 cause no request and no status change.
- R10: A write of 0xF1 to the command byte (apmSel=0) sets control bit 0, and a write of 0xF0 clears it. This takes priority over a control write at the same edge. The command byte and the scratch byte (apmSel=1) store and read back their written values.
- R11: smiReq is high for the single cycle after each command-byte write made while smiEnable is high, and stays low otherwise.
- R12: A pwrBtn pulse sets status bit 8 only when enable bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer tick strobe at the PM timer rate |
| busAddr | input | 6 | Register offset for reads and writes |
| busWrite | input | 1 | Register write strobe |
| busWdata | input | 16 | Register write data |
| busRdata | output | 32 | Register read data for busAddr |
| apmWrite | input | 1 | Command/status byte write strobe |
| apmSel | input | 1 | 0 selects the command byte, 1 selects the scratch byte |
| apmWdata | input | 8 | Command/status byte write data |
| apmRdata | output | 8 | Selected command/status byte |
| smiEnable | input | 1 | Allows command writes to request an SMI |
| pwrBtn | input | 1 | Power-button event pulse |
| sci | output | 1 | Level system-control interrupt |
| smiReq | output | 1 | One-cycle SMI request |
| shutdownReq | output | 1 | One-cycle power-off request |
| resetReq | output | 1 | One-cycle resume reset request |

## Verification
The bench builds the block with TMR_W = 8, so the overflow flag toggles every 128 ticks instead of every 8M. This puts many flag events and several full wraps of the timer inside a short run. The timer readback check then also covers the zero-extension of the upper 24 bits. Random sequences mix ticks, clearing writes, control writes with random sleep fields, magic and ordinary command bytes, and button events. Directed cases cover the two overflow edges, the set-beats-clear priority, and each sleep type.

// File: rtl/acpiPmPkg.sv
package acpiPmPkg;
  localparam logic [5:0] OFF_STS = 6'h00;
  localparam logic [5:0] OFF_EN  = 6'h02;
  localparam logic [5:0] OFF_CTL = 6'h04;
  localparam logic [5:0] OFF_TMR = 6'h08;

  localparam int BIT_TMR = 0;
  localparam int BIT_PWR = 8;
  localparam int BIT_RSM = 15;
  localparam int BIT_SLP = 13;
  localparam int SLP_LO  = 10;
  localparam logic [15:0] SCI_MASK = 16'h0521;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;

  typedef struct packed {
    logic stsClrWr;
    logic enWr;
    logic ctlWr;
    logic sleepResume;
    logic sciSet;
    logic sciClr;
    logic apmCmdWr;
    logic apmStsWr;
  } pmStrobes_t;
endpackage

// File: rtl/acpiPmCtrl.sv
module acpiPmCtrl
  import acpiPmPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  input  logic        apmWrite,
  input  logic        apmSel,
  input  logic [7:0]  apmWdata,
  input  logic        smiEnable,
  output pmStrobes_t  strobes,
  output logic        smiReq,
  output logic        shutdownReq,
  output logic        resetReq
);
  logic [2:0] sleepType;
  logic       sleepGo;
  logic       sleepOff;

  assign sleepType = busWdata[SLP_LO +: 3];

  always_comb begin
    strobes          = '0;
    strobes.stsClrWr = busWrite && (busAddr == OFF_STS);
    strobes.enWr     = busWrite && (busAddr == OFF_EN);
    strobes.ctlWr    = busWrite && (busAddr == OFF_CTL);
    strobes.apmCmdWr = apmWrite && !apmSel;
    strobes.apmStsWr = apmWrite && apmSel;
    strobes.sciSet   = strobes.apmCmdWr && (apmWdata == APM_SCI_ON);
    strobes.sciClr   = strobes.apmCmdWr && (apmWdata == APM_SCI_OFF);
    sleepGo          = strobes.ctlWr && busWdata[BIT_SLP];
    sleepOff         = sleepGo && (sleepType == 3'd0);
    strobes.sleepResume = sleepGo && (sleepType == 3'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smiReq      <= 1'b0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      smiReq      <= strobes.apmCmdWr && smiEnable;
      shutdownReq <= sleepOff;
      resetReq    <= strobes.sleepResume;
    end
  end

  // R8: a power-off pulse follows a control write carrying sleep type 0
  a_r8_off_cause: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busWrite && busAddr == OFF_CTL && busWdata[13] && busWdata[12:10] == 3'd0));
  // R9: a reset pulse follows a control write carrying sleep type 1
  a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busWrite && busAddr == OFF_CTL && busWdata[13] && busWdata[12:10] == 3'd1));
  // R11: an SMI pulse needs a command write while enabled
  a_r11_smi_cause: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(apmWrite && !apmSel && smiEnable));
  a_r11_smi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !smiEnable |=> !smiReq);
endmodule

// File: rtl/acpiPmDatapath.sv
module acpiPmDatapath
  import acpiPmPkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        pwrBtn,
  input  pmStrobes_t  strobes,
  input  logic [5:0]  busAddr,
  input  logic [15:0] busWdata,
  input  logic        apmSel,
  input  logic [7:0]  apmWdata,
  output logic [31:0] busRdata,
  output logic [7:0]  apmRdata,
  output logic        sci
);
  localparam int PAD_W = 32 - TMR_W;
  localparam int MSB   = TMR_W - 1;

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] tmrInc;
  logic [15:0] sts, en, ctl;
  logic [15:0] stsSet, stsNext, ctlNext;
  logic [7:0]  apmCmd, apmSts;
  logic        tmrOvf;

  assign tmrInc = tmr + 1'b1;
  assign tmrOvf = tickEn && (tmrInc[MSB] != tmr[MSB]);

  always_comb begin
    stsSet = '0;
    stsSet[BIT_TMR] = tmrOvf;
    stsSet[BIT_PWR] = (pwrBtn && en[BIT_PWR]) || strobes.sleepResume;
    stsSet[BIT_RSM] = strobes.sleepResume;
    stsNext = (strobes.stsClrWr ? (sts & ~busWdata) : sts) | stsSet;

    ctlNext = ctl;
    if (strobes.ctlWr) begin
      ctlNext = busWdata;
      ctlNext[BIT_SLP] = 1'b0;
    end
    if (strobes.sciSet) ctlNext[0] = 1'b1;
    if (strobes.sciClr) ctlNext[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr    <= '0;
      sts    <= '0;
      en     <= '0;
      ctl    <= '0;
      apmCmd <= '0;
      apmSts <= '0;
    end else begin
      if (tickEn) tmr <= tmrInc;
      sts <= stsNext;
      ctl <= ctlNext;
      if (strobes.enWr)     en     <= busWdata;
      if (strobes.apmCmdWr) apmCmd <= apmWdata;
      if (strobes.apmStsWr) apmSts <= apmWdata;
    end
  end

  always_comb begin
    case (busAddr)
      OFF_STS: busRdata = {16'h0, sts};
      OFF_EN:  busRdata = {16'h0, en};
      OFF_CTL: busRdata = {16'h0, ctl};
      OFF_TMR: busRdata = {{PAD_W{1'b0}}, tmr};
      default: busRdata = '0;
    endcase
  end

  assign apmRdata = apmSel ? apmSts : apmCmd;
  assign sci      = |(sts & en & SCI_MASK);

  // R2: timer holds without a tick and steps by one with one
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmr));
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> tmr == TMR_W'($past(tmr) + 1'b1));
  // R3: a tick out of a value with all low bits set raises the overflow flag
  a_r3_flag: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && (&tmr[MSB-1:0])) |=> sts[BIT_TMR]);
  // R12: a button event cannot set its status bit while disabled
  a_r12_gate: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtn && !en[BIT_PWR] && !strobes.sleepResume && !sts[BIT_PWR]) |=> !sts[BIT_PWR]);
  // R10: magic command values drive the SCI-enable bit
  a_r10_on: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sciSet |=> ctl[0]);
  a_r10_off: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sciClr |=> !ctl[0]);
endmodule

// File: rtl/acpiPmUnit.sv
module acpiPmUnit
  import acpiPmPkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [5:0]  busAddr,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        apmWrite,
  input  logic        apmSel,
  input  logic [7:0]  apmWdata,
  output logic [7:0]  apmRdata,
  input  logic        smiEnable,
  input  logic        pwrBtn,
  output logic        sci,
  output logic        smiReq,
  output logic        shutdownReq,
  output logic        resetReq
);
  pmStrobes_t strobes;

  acpiPmCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .apmWrite(apmWrite), .apmSel(apmSel),
    .apmWdata(apmWdata), .smiEnable(smiEnable), .strobes(strobes),
    .smiReq(smiReq), .shutdownReq(shutdownReq), .resetReq(resetReq)
  );

  acpiPmDatapath #(.TMR_W(TMR_W)) uData (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pwrBtn(pwrBtn),
    .strobes(strobes), .busAddr(busAddr), .busWdata(busWdata),
    .apmSel(apmSel), .apmWdata(apmWdata), .busRdata(busRdata),
    .apmRdata(apmRdata), .sci(sci)
  );
endmodule

// File: tb/acpiPmUnit_test.sv
module acpiPmUnit_test;
  localparam int PERIOD = 20;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, busWrite = 1'b0, apmWrite = 1'b0, apmSel = 1'b0;
  logic smiEnable = 1'b0, pwrBtn = 1'b0;
  logic [5:0] busAddr = 6'h0;
  logic [15:0] busWdata = 16'h0;
  logic [7:0] apmWdata = 8'h0;
  logic [31:0] busRdata;
  logic [7:0] apmRdata;
  logic sci, smiReq, shutdownReq, resetReq;

  int checks = 0;
  int fails = 0;

  logic [15:0] mSts = 0, mEn = 0, mCtl = 0;
  logic [7:0] mCmd = 0, mScr = 0;
  logic [TW-1:0] mTmr = 0;
  logic eOff = 0, eRst = 0, eSmi = 0;

  always #(PERIOD/2) clk = ~clk;

  acpiPmUnit #(.TMR_W(TW)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .apmWrite(apmWrite), .apmSel(apmSel), .apmWdata(apmWdata),
    .apmRdata(apmRdata), .smiEnable(smiEnable), .pwrBtn(pwrBtn),
    .sci(sci), .smiReq(smiReq), .shutdownReq(shutdownReq), .resetReq(resetReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expSci(logic [15:0] s, logic [15:0] e);
    return |(s & e & 16'h0521);
  endfunction

  task automatic readAll();
    busAddr = 6'h00; #1 chk("R4 status read", busRdata, {16'h0, mSts});
    busAddr = 6'h02; #1 chk("R5 enable read", busRdata, {16'h0, mEn});
    busAddr = 6'h04; #1 chk("R7 control read", busRdata, {16'h0, mCtl});
    busAddr = 6'h08; #1 chk("R2 timer read", busRdata, {24'h0, mTmr});
    busAddr = 6'h06; #1 chk("R5 unmapped read", busRdata, 32'h0);
    apmSel = 1'b0;   #1 chk("R10 command byte", {24'h0, apmRdata}, {24'h0, mCmd});
    apmSel = 1'b1;   #1 chk("R10 scratch byte", {24'h0, apmRdata}, {24'h0, mScr});
  endtask

  task automatic step(bit tk, bit wr, logic [5:0] a, logic [15:0] d,
                      bit aw, bit as, logic [7:0] ad, bit pb, bit se);
    logic [15:0] nSts, nCtl;
    logic [TW-1:0] nTmr;
    @(negedge clk);
    tickEn = tk; busWrite = wr; busAddr = a; busWdata = d;
    apmWrite = aw; apmSel = as; apmWdata = ad; pwrBtn = pb; smiEnable = se;
    nSts = mSts;
    if (wr && a == 6'h00) nSts = nSts & ~d;
    nTmr = mTmr + (tk ? 1 : 0);
    if (tk && nTmr[TW-1] != mTmr[TW-1]) nSts[0] = 1'b1;
    if (pb && mEn[8]) nSts[8] = 1'b1;
    eOff = wr && a == 6'h04 && d[13] && d[12:10] == 3'd0;
    eRst = wr && a == 6'h04 && d[13] && d[12:10] == 3'd1;
    if (eRst) nSts = nSts | 16'h8100;
    nCtl = mCtl;
    if (wr && a == 6'h04) nCtl = d & 16'hDFFF;
    if (aw && !as && ad == 8'hF1) nCtl[0] = 1'b1;
    if (aw && !as && ad == 8'hF0) nCtl[0] = 1'b0;
    eSmi = aw && !as && se;
    @(posedge clk); #1;
    tickEn = 0; busWrite = 0; apmWrite = 0; pwrBtn = 0;
    mSts = nSts; mCtl = nCtl; mTmr = nTmr;
    if (wr && a == 6'h02) mEn = d;
    if (aw && !as) mCmd = ad;
    if (aw && as) mScr = ad;
    chk("R8 shutdownReq", {31'h0, shutdownReq}, {31'h0, eOff});
    chk("R9 resetReq", {31'h0, resetReq}, {31'h0, eRst});
    chk("R11 smiReq", {31'h0, smiReq}, {31'h0, eSmi});
    chk("R6 sci", {31'h0, sci}, {31'h0, expSci(mSts, mEn)});
    readAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 6'h06, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 sci", {31'h0, sci}, 32'h0);
    chk("R1 shutdownReq", {31'h0, shutdownReq}, 32'h0);
    chk("R1 resetReq", {31'h0, resetReq}, 32'h0);
    chk("R1 smiReq", {31'h0, smiReq}, 32'h0);
    readAll();
    @(negedge clk); rstN = 1'b1;

    // R3 overflow at 0x7F->0x80, cleared, then again at 0xFF->0x00
    for (int i = 0; i < 127; i++) step(1, 0, 6'h06, 0, 0, 0, 0, 0, 0);
    chk("R3 no flag before MSB toggle", {31'h0, busRdata[0]}, 32'h0);
    step(1, 0, 6'h00, 0, 0, 0, 0, 0, 0);
    busAddr = 6'h00; #1 chk("R3 flag at rising MSB", {31'h0, busRdata[0]}, 32'h1);
    step(0, 1, 6'h00, 16'h0001, 0, 0, 0, 0, 0);
    chk("R4 clear by writing one", {31'h0, mSts[0]}, 32'h0);
    for (int i = 0; i < 127; i++) step(1, 0, 6'h06, 0, 0, 0, 0, 0, 0);
    // R4 set wins: tick to wrap and clear in the same cycle
    step(1, 1, 6'h00, 16'hFFFF, 0, 0, 0, 0, 0);
    busAddr = 6'h08; #1 chk("R2 timer wrapped", busRdata, 32'h0);
    busAddr = 6'h00; #1 chk("R3 R4 flag at falling MSB beats clear", busRdata, 32'h1);
    // R6 sci follows enable
    step(0, 1, 6'h02, 16'h0001, 0, 0, 0, 0, 0);
    chk("R6 sci with overflow enabled", {31'h0, sci}, 32'h1);
    step(0, 1, 6'h00, 16'h0001, 0, 0, 0, 0, 0);
    chk("R6 sci drops after clear", {31'h0, sci}, 32'h0);
    // R5 unmapped writes ignored, timer writes ignored
    step(0, 1, 6'h0A, 16'hFFFF, 0, 0, 0, 0, 0);
    step(0, 1, 6'h08, 16'h1234, 0, 0, 0, 0, 0);
    // R12 button gating
    step(0, 0, 6'h06, 0, 0, 0, 0, 1, 0);
    chk("R12 button ignored when disabled", {31'h0, mSts[8]}, 32'h0);
    step(0, 1, 6'h02, 16'h0100, 0, 0, 0, 0, 0);
    step(0, 0, 6'h06, 0, 0, 0, 0, 1, 0);
    busAddr = 6'h00; #1 chk("R12 button sets bit 8", {31'h0, busRdata[8]}, 32'h1);
    step(0, 1, 6'h00, 16'h0100, 0, 0, 0, 0, 0);
    // R7 R8 R9 sleep types
    step(0, 1, 6'h04, 16'h2000, 0, 0, 0, 0, 0);
    chk("R8 type 0 power-off", {31'h0, shutdownReq}, 32'h1);
    chk("R7 sleep bit not stored", {16'h0, mCtl}, 32'h0);
    step(0, 1, 6'h04, 16'h2401, 0, 0, 0, 0, 0);
    busAddr = 6'h00; #1 chk("R9 type 1 status", busRdata & 32'h8100, 32'h8100);
    step(0, 1, 6'h00, 16'hFFFF, 0, 0, 0, 0, 0);
    step(0, 1, 6'h04, 16'h2C00, 0, 0, 0, 0, 0);
    chk("R9 type 3 no request", {30'h0, resetReq, shutdownReq}, 32'h0);
    // R10 R11 magic commands
    step(0, 0, 6'h06, 0, 1, 0, 8'hF1, 0, 1);
    busAddr = 6'h04; #1 chk("R10 F1 sets bit 0", {31'h0, busRdata[0]}, 32'h1);
    step(0, 0, 6'h06, 0, 1, 0, 8'hF0, 0, 0);
    busAddr = 6'h04; #1 chk("R10 F0 clears bit 0", {31'h0, busRdata[0]}, 32'h0);
    step(0, 0, 6'h06, 0, 1, 1, 8'h5A, 0, 1);
    chk("R11 scratch write no SMI", {31'h0, smiReq}, 32'h0);
    idle(2);

    // random mix
    for (int n = 0; n < 2500; n++) begin
      logic [5:0] a;
      logic [15:0] d;
      logic [7:0] ad;
      case ($urandom % 6)
        0: a = 6'h00;
        1: a = 6'h02;
        2: a = 6'h04;
        3: a = 6'h08;
        4: a = 6'h06;
        default: a = 6'h3E;
      endcase
      d = 16'($urandom);
      case ($urandom % 4)
        0: ad = 8'hF1;
        1: ad = 8'hF0;
        default: ad = 8'($urandom);
      endcase
      step(($urandom % 2) == 0, ($urandom % 3) == 0, a, d,
           ($urandom % 4) == 0, ($urandom % 2) == 0, ad,
           ($urandom % 5) == 0, ($urandom % 2) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule